// File: doc/BRIEF.md
# Write-Once Watchdog Control Unit

This block is a watchdog timer steered by one 8-bit control register. Boot defaults for the register arrive once per boot from a nonvolatile source, which is modelled as a data bus with a load strobe. After that, software may change the register under rules that depend on the operating mode. In normal mode the enable-type fields accept exactly one write, and a write that changes nothing still uses up that chance. In special mode, used for test and debug, the fields can be rewritten at will.

The counter advances on ticks from one of two clock sources. The internal reference tick is used by default, and the oscillator tick is used when the oscillator is selected and reported up. Whenever the effective source changes, the timeout period starts again. In stop mode the counter freezes unless a specific set of qualifiers keeps it alive. When the count reaches the end of the chosen period, the block pulses a reset request for one cycle and starts a new period. The request also re-arms the once-per-boot load and the one normal-mode write.

The period is 2^(BASE_EXP + STEP_EXP*rate) ticks. The defaults, BASE_EXP=13 and STEP_EXP=2, give 2^(13+2*rate).

Top module: `wonce_wdog`

## Requirements
- R1: Out of reset every field is 0 and no request is raised. The readback places the window-enable bit at bit 7, the stop-backdoor bit at bit 6 and the rate at bits 2:0. Bits 5:3 always read 0, and this includes the write-mask bit 5.
- R2: The first nonvolatile load after reset (or after a reset request) copies bit 7, bit 6 and bits 2:0 of the load bus into the register. Every further load in that boot is ignored.
- R3: When the rate is non-zero, the timeout fires after 2^(BASE_EXP + STEP_EXP*rate) selected ticks counted from the last restart. It raises the request for exactly one cycle and begins a new, identical period. A non-zero nonvolatile load counts as a restart.
- R4: While the rate is 0 the watchdog is disabled and never raises a request.
- R5: The effective source is the oscillator when the select input and the oscillator-up input are both 1. In every other case it is the internal reference. Only ticks of the effective source advance the count.
- R6: Any change of the effective source restarts the timeout period. This covers a change of the select input and a loss or gain of oscillator-up.
- R7: While stop is asserted the count holds its value, unless pseudo-stop, the effective oscillator source and the oscillator-enable qualifier are all 1. A held count resumes from where it stopped.
- R8: In normal mode, window-enable and rate change only on the first write of the boot that has bit 5 (write-mask) at 0. Writes with bit 5 set have no effect on these fields, and later writes in the same boot are ignored.
- R9: In normal mode, writing rate 000 or window-enable 0 leaves the field unchanged. Such a write still uses up the single normal-mode write.
- R10: The stop-backdoor bit (bit 6) does not depend on bit 5. In normal mode it can only be set, and the 0-to-1 change restarts the timeout. In special mode it takes the written value.
- R11: In normal mode, the accepted write restarts the timeout when it carries a non-zero rate or window-enable 1.
- R12: In special mode, every write with bit 5 at 0 updates window-enable and rate. Every write, masked or not, restarts the timeout.
- R13: A reset request re-arms the nonvolatile load and the single normal-mode write. A write in the cycle right after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode_i | input | 1 | 1 selects special (test) mode |
| nv_load_i | input | 1 | Nonvolatile default load strobe |
| nv_data_i | input | 8 | Nonvolatile default value |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback |
| sel_osc_i | input | 1 | Requests the oscillator as tick source |
| osc_up_i | input | 1 | Oscillator is running and stable |
| irc_tick_i | input | 1 | Tick from the internal reference clock |
| osc_tick_i | input | 1 | Tick from the oscillator clock |
| stop_i | input | 1 | Device is in stop mode |
| pseudo_stop_i | input | 1 | Stop mode is pseudo-stop |
| osc_en_i | input | 1 | Oscillator-enable qualifier for stop mode |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The bench measures the exact tick distance from each restart source to the request, which exposes a missing restart in one of two ways. If the restart is skipped, the period comes out short. If the restart is applied twice, the period comes out long. The bench also covers the once-only rule. The checks cover a dummy write that must still use up the chance, a masked write that must not use it up, and a write in the cycle right after a request that must be accepted rather than dropped. In stop mode, a design that cleared the count, instead of holding it, would report a full period after release and fail the check. The bench also removes one qualifier at a time to catch a design that keeps counting in stop mode with any qualifier missing.

// File: rtl/wonce_pkg.sv
package wonce_pkg;

    localparam int RATE_W = 3;
    localparam int RATE_MAX = (1 << RATE_W) - 1;

    typedef struct packed {
        logic              win;
        logic              bd;
        logic [RATE_W-1:0] rate;
        logic              used;
        logic              armed;
    } ctl_state_t;

    typedef struct packed {
        logic sel;
    } src_state_t;

endpackage

// File: rtl/wonce_regs.sv
module wonce_regs
    import wonce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special_i,
    input  logic              nv_load_i,
    input  logic [7:0]        nv_data_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              clear_i,
    output logic              win_o,
    output logic              bd_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              restart_o
);

    localparam int WIN_BIT  = 7;
    localparam int BD_BIT   = 6;
    localparam int MASK_BIT = 5;

    ctl_state_t st_d, st_q;
    logic       used_now;
    logic       armed_now;
    logic       load_take;
    logic       unused_bits;

    assign unused_bits = ^{nv_data_i[5:3], wr_data_i[4:3]};

    always_comb begin
        st_d      = st_q;
        restart_o = 1'b0;
        // a timeout request opens a fresh boot before anything else is applied
        used_now  = st_q.used & ~clear_i;
        armed_now = st_q.armed | clear_i;
        load_take = nv_load_i & armed_now;
        st_d.used  = used_now;
        st_d.armed = armed_now;

        if (load_take) begin
            st_d.win   = nv_data_i[WIN_BIT];
            st_d.bd    = nv_data_i[BD_BIT];
            st_d.rate  = nv_data_i[RATE_W-1:0];
            st_d.armed = 1'b0;
            restart_o  = (nv_data_i[RATE_W-1:0] != '0);
        end else if (wr_en_i) begin
            if (special_i) begin
                restart_o = 1'b1;
                st_d.bd   = wr_data_i[BD_BIT];
                if (!wr_data_i[MASK_BIT]) begin
                    st_d.win  = wr_data_i[WIN_BIT];
                    st_d.rate = wr_data_i[RATE_W-1:0];
                end
            end else begin
                if (!wr_data_i[MASK_BIT] && !used_now) begin
                    st_d.used = 1'b1;
                    if (wr_data_i[RATE_W-1:0] != '0) begin
                        st_d.rate = wr_data_i[RATE_W-1:0];
                        restart_o = 1'b1;
                    end
                    if (wr_data_i[WIN_BIT]) begin
                        st_d.win  = 1'b1;
                        restart_o = 1'b1;
                    end
                end
                if (wr_data_i[BD_BIT] && !st_q.bd) begin
                    st_d.bd   = 1'b1;
                    restart_o = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{win: 1'b0, bd: 1'b0, rate: '0, used: 1'b0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o  = st_q.win;
    assign bd_o   = st_q.bd;
    assign rate_o = st_q.rate;

    // R8: once the normal-mode write is spent, fields hold until a new boot
    a_r8_once_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_i && st_q.used && !clear_i && !nv_load_i)
        |=> ($stable(st_q.rate) && $stable(st_q.win)));

    // R10: in normal mode the backdoor bit never falls
    a_r10_bd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_i && st_q.bd && !(nv_load_i && (st_q.armed || clear_i)))
        |=> st_q.bd);

    // R2: a second load in the same boot leaves the fields untouched
    a_r2_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_load_i && !st_q.armed && !clear_i && !wr_en_i)
        |=> ($stable(st_q.rate) && $stable(st_q.win) && $stable(st_q.bd)));

endmodule

// File: rtl/wonce_clksel.sv
module wonce_clksel
    import wonce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_osc_i,
    input  logic osc_up_i,
    input  logic irc_tick_i,
    input  logic osc_tick_i,
    input  logic stop_i,
    input  logic pseudo_stop_i,
    input  logic osc_en_i,
    output logic tick_o,
    output logic changed_o,
    output logic halt_o
);

    src_state_t src_d, src_q;
    logic       sel_eff;
    logic       keep_alive;

    always_comb begin
        sel_eff    = sel_osc_i & osc_up_i;
        src_d.sel  = sel_eff;
        changed_o  = sel_eff ^ src_q.sel;
        tick_o     = sel_eff ? osc_tick_i : irc_tick_i;
        keep_alive = pseudo_stop_i & sel_eff & osc_en_i;
        halt_o     = stop_i & ~keep_alive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '{sel: 1'b0};
        end else begin
            src_q <= src_d;
        end
    end

endmodule

// File: rtl/wonce_counter.sv
module wonce_counter
    import wonce_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int STEP_EXP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              tick_i,
    input  logic              halt_i,
    input  logic              restart_i,
    output logic              req_o
);

    localparam int CNT_W = BASE_EXP + STEP_EXP * RATE_MAX;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;
    logic [CNT_W:0] last_val;
    int unsigned    shamt;

    always_comb begin
        shamt    = BASE_EXP + STEP_EXP * int'(rate_i);
        last_val = ({{CNT_W{1'b0}}, 1'b1} << shamt) - 1'b1;
        cs_d     = cs_q;
        cs_d.req = 1'b0;
        if (restart_i || rate_i == '0) begin
            cs_d.cnt = '0;
        end else if (tick_i && !halt_i) begin
            if ({1'b0, cs_q.cnt} == last_val) begin
                cs_d.cnt = '0;
                cs_d.req = 1'b1;
            end else begin
                cs_d.cnt = cs_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{cnt: '0, req: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign req_o = cs_q.req;

    // R3: the request lasts one cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.req |=> !cs_q.req);

    // R4: a disabled watchdog stays quiet
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == '0) |=> !cs_q.req);

    // R7: a halted count holds its value
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !restart_i && rate_i != '0) |=> $stable(cs_q.cnt));

    // R11: a restart always begins from zero
    a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cs_q.cnt == '0 && !cs_q.req));

endmodule

// File: rtl/wonce_wdog.sv
module wonce_wdog
    import wonce_pkg::*;
#(
    parameter int BASE_EXP = 13,
    parameter int STEP_EXP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode_i,
    input  logic       nv_load_i,
    input  logic [7:0] nv_data_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       sel_osc_i,
    input  logic       osc_up_i,
    input  logic       irc_tick_i,
    input  logic       osc_tick_i,
    input  logic       stop_i,
    input  logic       pseudo_stop_i,
    input  logic       osc_en_i,
    output logic       rst_req_o
);

    logic              win;
    logic              bd;
    logic [RATE_W-1:0] rate;
    logic              wr_restart;
    logic              src_change;
    logic              tick;
    logic              halt;
    logic              req;

    wonce_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .special_i (special_mode_i),
        .nv_load_i (nv_load_i),
        .nv_data_i (nv_data_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .clear_i   (req),
        .win_o     (win),
        .bd_o      (bd),
        .rate_o    (rate),
        .restart_o (wr_restart)
    );

    wonce_clksel u_clksel (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_osc_i     (sel_osc_i),
        .osc_up_i      (osc_up_i),
        .irc_tick_i    (irc_tick_i),
        .osc_tick_i    (osc_tick_i),
        .stop_i        (stop_i),
        .pseudo_stop_i (pseudo_stop_i),
        .osc_en_i      (osc_en_i),
        .tick_o        (tick),
        .changed_o     (src_change),
        .halt_o        (halt)
    );

    wonce_counter #(
        .BASE_EXP (BASE_EXP),
        .STEP_EXP (STEP_EXP)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_i    (rate),
        .tick_i    (tick),
        .halt_i    (halt),
        .restart_i (wr_restart | src_change),
        .req_o     (req)
    );

    assign rd_data_o = {win, bd, 3'b000, rate};
    assign rst_req_o = req;

    // R1: unimplemented and mask positions always read zero
    a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[5:3] == 3'b000);

endmodule

// File: tb/wonce_wdog_bench.sv
`timescale 1ns/1ps
module wonce_wdog_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       nv_load = 1'b0;
    logic [7:0] nv_data = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sel_osc = 1'b0;
    logic       osc_up = 1'b0;
    logic       irc_tick = 1'b1;
    logic       osc_tick = 1'b1;
    logic       stop = 1'b0;
    logic       pseudo_stop = 1'b0;
    logic       osc_en = 1'b0;
    logic       rst_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // bench uses period = 2^(4 + rate)
    wonce_wdog #(.BASE_EXP(4), .STEP_EXP(1)) u_wonce_wdog (
        .clk            (clk),
        .rst_n          (rst_n),
        .special_mode_i (special_mode),
        .nv_load_i      (nv_load),
        .nv_data_i      (nv_data),
        .wr_en_i        (wr_en),
        .wr_data_i      (wr_data),
        .rd_data_o      (rd_data),
        .sel_osc_i      (sel_osc),
        .osc_up_i       (osc_up),
        .irc_tick_i     (irc_tick),
        .osc_tick_i     (osc_tick),
        .stop_i         (stop),
        .pseudo_stop_i  (pseudo_stop),
        .osc_en_i       (osc_en),
        .rst_req_o      (rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit spec);
        @(negedge clk);
        rst_n = 1'b0;
        special_mode = spec;
        nv_load = 1'b0; wr_en = 1'b0; nv_data = '0; wr_data = '0;
        sel_osc = 1'b0; osc_up = 1'b0; irc_tick = 1'b1; osc_tick = 1'b1;
        stop = 1'b0; pseudo_stop = 1'b0; osc_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic nv_put(input logic [7:0] d);
        @(negedge clk);
        nv_load = 1'b1; nv_data = d;
        @(posedge clk);
        #1 nv_load = 1'b0;
    endtask

    task automatic wr_put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic count_req(input int max, output int n);
        n = -1;
        for (int i = 1; i <= max; i++) begin
            @(posedge clk);
            #1;
            if (rst_req) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        #1;
        check(rd_data == 8'h00, "R1 reset readback", rd_data, 8'h00);
        check(rst_req == 1'b0, "R1 reset request", rst_req, 0);
    endtask

    task automatic t_load_and_period();
        int n;
        do_reset(1'b0);
        nv_put(8'hB9);   // win=1 bd=0 mask bit set rate=1: bit5 and bits 4:3 read 0
        check(rd_data == 8'h81, "R1 R2 load readback", rd_data, 8'h81);
        nv_put(8'h03);
        check(rd_data == 8'h81, "R2 second load ignored", rd_data, 8'h81);
        count_req(200, n);
        check(n == 31, "R3 period after ignored load", n, 31);
        edges(1);
        check(rst_req == 1'b0, "R3 single-cycle request", rst_req, 0);
        count_req(200, n);
        check(n == 31, "R3 reload period", n, 31);
    endtask

    task automatic t_disabled();
        int n;
        do_reset(1'b0);
        nv_put(8'h80);
        check(rd_data == 8'h80, "R4 load rate zero", rd_data, 8'h80);
        count_req(300, n);
        check(n == -1, "R4 no request when disabled", n, -1);
    endtask

    task automatic t_normal_write();
        int n;
        do_reset(1'b0);
        nv_put(8'h01);
        wr_put(8'h23);
        check(rd_data == 8'h01, "R8 masked write ignored", rd_data, 8'h01);
        wr_put(8'h03);
        check(rd_data == 8'h03, "R8 first write taken", rd_data, 8'h03);
        count_req(400, n);
        check(n == 128, "R11 restart on rate write", n, 128);
        wr_put(8'h02);
        check(rd_data == 8'h02, "R13 write after request", rd_data, 8'h02);
        nv_put(8'h85);
        check(rd_data == 8'h85, "R13 load re-armed", rd_data, 8'h85);

        do_reset(1'b0);
        nv_put(8'h01);
        wr_put(8'h02);
        wr_put(8'h85);
        check(rd_data == 8'h02, "R8 later write ignored", rd_data, 8'h02);
    endtask

    task automatic t_dummy_write();
        do_reset(1'b0);
        nv_put(8'h02);
        wr_put(8'h00);
        check(rd_data == 8'h02, "R9 dummy write no change", rd_data, 8'h02);
        wr_put(8'h83);
        check(rd_data == 8'h02, "R9 dummy write used the chance", rd_data, 8'h02);
    endtask

    task automatic t_backdoor();
        int n;
        do_reset(1'b0);
        nv_put(8'h01);
        edges(10);
        wr_put(8'h60);
        check(rd_data == 8'h41, "R10 backdoor set with mask", rd_data, 8'h41);
        count_req(200, n);
        check(n == 32, "R10 R11 restart on backdoor set", n, 32);
        wr_put(8'h00);
        check(rd_data == 8'h41, "R10 backdoor not cleared in normal", rd_data, 8'h41);

        do_reset(1'b1);
        nv_put(8'h45);
        wr_put(8'h05);
        check(rd_data == 8'h05, "R10 backdoor cleared in special", rd_data, 8'h05);
    endtask

    task automatic t_special();
        int n;
        do_reset(1'b1);
        nv_put(8'h01);
        wr_put(8'h02);
        check(rd_data == 8'h02, "R12 special write one", rd_data, 8'h02);
        wr_put(8'h85);
        check(rd_data == 8'h85, "R12 special write two", rd_data, 8'h85);
        wr_put(8'h05);
        check(rd_data == 8'h05, "R12 special clears window", rd_data, 8'h05);
        edges(10);
        wr_put(8'h22);
        check(rd_data == 8'h05, "R12 masked special write", rd_data, 8'h05);
        count_req(700, n);
        check(n == 512, "R12 masked write restarts", n, 512);
    endtask

    task automatic t_source();
        int n;
        do_reset(1'b0);
        sel_osc = 1'b1; osc_up = 1'b1; osc_tick = 1'b0;
        nv_put(8'h01);
        count_req(200, n);
        check(n == -1, "R5 reference ticks ignored on oscillator", n, -1);
        @(negedge clk);
        osc_up = 1'b0;
        @(posedge clk);
        #1;
        count_req(200, n);
        check(n == 32, "R5 R6 fallback to reference restarts", n, 32);
        edges(10);
        @(negedge clk);
        osc_up = 1'b1; osc_tick = 1'b1;
        @(posedge clk);
        #1;
        count_req(200, n);
        check(n == 32, "R6 restart on gain of oscillator", n, 32);
    endtask

    task automatic t_stop();
        int n;
        do_reset(1'b0);
        nv_put(8'h01);
        edges(10);
        stop = 1'b1;
        edges(50);
        check(rst_req == 1'b0, "R7 halted in stop", rst_req, 0);
        stop = 1'b0;
        count_req(200, n);
        check(n == 22, "R7 resume from held count", n, 22);

        @(negedge clk);
        sel_osc = 1'b1; osc_up = 1'b1; osc_en = 1'b1; pseudo_stop = 1'b1; stop = 1'b1;
        @(posedge clk);
        #1;
        count_req(200, n);
        check(n == 32, "R7 runs in pseudo-stop with qualifiers", n, 32);
        osc_en = 1'b0;
        count_req(100, n);
        check(n == -1, "R7 halts without oscillator enable", n, -1);
        osc_en = 1'b1; pseudo_stop = 1'b0;
        count_req(100, n);
        check(n == -1, "R7 halts in full stop", n, -1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_load_and_period();
        t_disabled();
        t_normal_write();
        t_dummy_write();
        t_backdoor();
        t_special();
        t_source();
        t_stop();
        finish_run();
    end

endmodule